// File: doc/BRIEF.md
# Branch Trace Sync Message Generator

This block sits beside a CPU's retirement stage. It turns taken-branch events into packed branch trace messages. Each emitted message is either a plain branch message or a synchronizing branch message. A plain message carries the target address XOR-compressed against the previously reported target. A synchronizing message carries the full target address, so a trace decoder can lock onto the stream at that point.

Between messages the block counts retired sequential instructions and places the count in the next message. It also counts emitted messages so that it can force periodic resynchronization. Many unrelated conditions can request a sync: reset, trace enable, leaving low-power or debug state, an external event, a change of instruction-encoding mode, a dropped secure-region branch, a message lost to a queue collision, and either counter wrapping. All of these set one shared pending flag, and the next emitted branch message takes it as a sync.

Each message leaves the block as a single registered word with a valid strobe, a sync flag and its total length in bits. Queueing and serialization happen downstream.

Top module: `trace_sync_msg_gen`

## Requirements
- R1: Message layout from bit 0 upward: a 6-bit code (sync = 6'b011101, plain = 6'b000100), the 4-bit source ID, the instruction count, the address field, then the history field. Count, address and history are each as wide as their highest set bit (at least 1 bit). `msg_len` is the total width, which lies between 13 and 82. Bits at and above `msg_len` are zero. A sync message carries the full target. A plain message carries the target XOR the target of the previous emitted message (zero after reset).
- R2: During and after reset, `msg_valid` and `msg_len` are 0 and every counter is clear. The first branch after reset with trace enabled yields a sync message.
- R3: A branch (`br_taken` with trace enabled, not secure, not lost) at clock edge k gives `msg_valid` high after edge k. Its count is the number of `instr_ret` strobes since the previous emitted message, plus 1 for the branch. An `instr_ret` in the same cycle as `br_taken` is not counted.
- R4: While `trace_en` is low, no message is emitted and the instruction count stays zero. The first message after `trace_en` rises is a sync.
- R5: A pulse on `lp_exit` makes the next emitted message a sync.
- R6: `evt_in` makes the next message a sync only when `evt_allow` and `trace_en` are both high. With `evt_allow` low it has no effect.
- R7: A pulse on `mode_sw` makes the next message a sync.
- R8: A branch with `br_secure` high emits nothing and clears the instruction count. The next message is a sync. `br_secure` takes priority over `br_lost`.
- R9: A branch with `br_lost` high (and `br_secure` low) emits nothing. The next message is a sync, and its count includes the lost branch.
- R10: When the instruction count would reach 255, it clears instead, and the next message is a sync.
- R11: When the 255th message since reset or since the last wrap is emitted, the message counter clears and the following message is a sync.
- R12: Any number of sync requests that arrive before a branch merge into one sync message. A request in the same cycle as a branch upgrades that branch. The pending flag clears when a sync message is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trace_en | input | 1 | Program trace enable |
| instr_ret | input | 1 | Sequential instruction retired |
| br_taken | input | 1 | Taken branch retired |
| br_target | input | ADDR_W | Branch target address |
| br_hist | input | HIST_W | Branch history bits |
| br_secure | input | 1 | Branch targets secure memory; its message is dropped |
| br_lost | input | 1 | Branch message lost to a queue collision |
| lp_exit | input | 1 | Leaving low-power or debug state |
| evt_in | input | 1 | External event request |
| evt_allow | input | 1 | Permits evt_in to request a sync |
| mode_sw | input | 1 | Instruction-encoding mode changed |
| msg_valid | output | 1 | Message present |
| msg_sync | output | 1 | Message is a sync message |
| msg_data | output | MSG_W | Packed message, LSB first |
| msg_len | output | LEN_W | Packed length in bits |

## Verification
Two functions can meet in one clock: a sync request (`lp_exit`, `mode_sw`, the rise of `trace_en`) and a branch that emits a message. The bench drives the request and `br_taken` in the same cycle, expects that very message to carry the sync code, and expects the next branch to be plain, so the request is neither lost nor counted twice. A second meeting is the `instr_ret` strobe in the same cycle as a branch. The bench judges it by the count field of the message that follows.

// File: rtl/tsm_pkg.sv
package tsm_pkg;
  localparam int TCODE_W = 6;
  localparam int SRCID_W = 4;
  localparam logic [TCODE_W-1:0] TC_SYNC  = 6'b011101;
  localparam logic [TCODE_W-1:0] TC_PLAIN = 6'b000100;

  // width of a value up to its highest set bit, never below one
  function automatic int top_bit_w(input logic [63:0] v);
    int w;
    w = 1;
    for (int i = 0; i < 64; i++) begin
      if (v[i]) w = i + 1;
    end
    return w;
  endfunction
endpackage

// File: rtl/tsm_counters.sv
module tsm_counters #(
  parameter int CNT_W  = 8,
  parameter int MCNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trace_en,
  input  logic             instr_ret,
  input  logic             br_taken,
  input  logic             branch_ok,
  input  logic             drop_sec,
  input  logic             drop_lost,
  output logic [CNT_W-1:0] seq_q,
  output logic [CNT_W-1:0] br_count,
  output logic             seq_ovf,
  output logic             msg_ovf
);
  localparam logic [CNT_W-1:0]  SEQ_MAX = '1;
  localparam logic [MCNT_W-1:0] MSG_MAX = '1;

  logic              seq_inc;
  logic [CNT_W-1:0]  seq_plus;
  logic [MCNT_W-1:0] mcnt_q, mcnt_plus;

  always_comb begin
    seq_inc   = drop_lost | (trace_en & instr_ret & ~br_taken);
    seq_plus  = seq_q + 1'b1;
    seq_ovf   = seq_inc && (seq_plus == SEQ_MAX);
    br_count  = seq_plus;
    mcnt_plus = mcnt_q + 1'b1;
    msg_ovf   = branch_ok && (mcnt_plus == MSG_MAX);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q <= '0;
    end else if (!trace_en || branch_ok || drop_sec) begin
      seq_q <= '0;
    end else if (seq_inc) begin
      seq_q <= seq_ovf ? '0 : seq_plus;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mcnt_q <= '0;
    end else if (branch_ok) begin
      mcnt_q <= msg_ovf ? '0 : mcnt_plus;
    end
  end
endmodule

// File: rtl/tsm_sync_ctrl.sv
module tsm_sync_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic trace_en,
  input  logic lp_exit,
  input  logic evt_in,
  input  logic evt_allow,
  input  logic mode_sw,
  input  logic branch_ok,
  input  logic drop_any,
  input  logic seq_ovf,
  input  logic msg_ovf,
  output logic pend_q,
  output logic make_sync
);
  logic en_q, en_rise, trig;

  always_comb begin
    en_rise   = trace_en & ~en_q;
    trig      = en_rise | lp_exit | (evt_in & evt_allow & trace_en) | mode_sw;
    make_sync = branch_ok & (pend_q | trig);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pend_q <= 1'b1;
    end else begin
      en_q <= trace_en;
      if (make_sync) pend_q <= msg_ovf | seq_ovf;
      else           pend_q <= pend_q | trig | drop_any | seq_ovf | msg_ovf;
    end
  end
endmodule

// File: rtl/tsm_packer.sv
module tsm_packer
  import tsm_pkg::*;
#(
  parameter int              ADDR_W = 32,
  parameter int              HIST_W = 32,
  parameter int              CNT_W  = 8,
  parameter logic [SRCID_W-1:0] SRC_ID = '0,
  parameter int              MSG_W  = 82,
  parameter int              LEN_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              is_sync,
  input  logic [CNT_W-1:0]  count,
  input  logic [ADDR_W-1:0] target,
  input  logic [HIST_W-1:0] hist,
  output logic              msg_valid,
  output logic              msg_sync,
  output logic [MSG_W-1:0]  msg_data,
  output logic [LEN_W-1:0]  msg_len
);
  logic [ADDR_W-1:0] last_q, addr_fld;
  logic [MSG_W-1:0]  pk;
  logic [LEN_W-1:0]  ln;
  int cw, aw, hw;

  always_comb begin
    addr_fld = is_sync ? target : (target ^ last_q);
    cw = top_bit_w(64'(count));
    aw = top_bit_w(64'(addr_fld));
    hw = top_bit_w(64'(hist));
    pk = MSG_W'(is_sync ? TC_SYNC : TC_PLAIN)
       | (MSG_W'(SRC_ID)   << TCODE_W)
       | (MSG_W'(count)    << (TCODE_W + SRCID_W))
       | (MSG_W'(addr_fld) << (TCODE_W + SRCID_W + cw))
       | (MSG_W'(hist)     << (TCODE_W + SRCID_W + cw + aw));
    ln = LEN_W'(TCODE_W + SRCID_W + cw + aw + hw);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_sync  <= 1'b0;
      msg_data  <= '0;
      msg_len   <= '0;
      last_q    <= '0;
    end else begin
      msg_valid <= fire;
      if (fire) begin
        msg_sync <= is_sync;
        msg_data <= pk;
        msg_len  <= ln;
        last_q   <= target;
      end
    end
  end
endmodule

// File: rtl/trace_sync_msg_gen.sv
module trace_sync_msg_gen
  import tsm_pkg::*;
#(
  parameter int                 ADDR_W = 32,
  parameter int                 HIST_W = 32,
  parameter int                 CNT_W  = 8,
  parameter int                 MCNT_W = 8,
  parameter logic [SRCID_W-1:0] SRC_ID = '0,
  localparam int                MSG_W  = TCODE_W + SRCID_W + CNT_W + ADDR_W + HIST_W,
  localparam int                LEN_W  = $clog2(MSG_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trace_en,
  input  logic              instr_ret,
  input  logic              br_taken,
  input  logic [ADDR_W-1:0] br_target,
  input  logic [HIST_W-1:0] br_hist,
  input  logic              br_secure,
  input  logic              br_lost,
  input  logic              lp_exit,
  input  logic              evt_in,
  input  logic              evt_allow,
  input  logic              mode_sw,
  output logic              msg_valid,
  output logic              msg_sync,
  output logic [MSG_W-1:0]  msg_data,
  output logic [LEN_W-1:0]  msg_len
);
  // named events shared by the sub-blocks and the checker
  logic branch_ok, drop_sec, drop_lost, drop_any;
  logic seq_ovf, msg_ovf, pend_q, make_sync;
  logic [CNT_W-1:0] seq_q, br_count;

  always_comb begin
    branch_ok = trace_en & br_taken & ~br_secure & ~br_lost;
    drop_sec  = trace_en & br_taken & br_secure;
    drop_lost = trace_en & br_taken & br_lost & ~br_secure;
    drop_any  = drop_sec | drop_lost;
  end

  tsm_counters #(.CNT_W(CNT_W), .MCNT_W(MCNT_W)) cnt_u (
    .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .instr_ret(instr_ret),
    .br_taken(br_taken), .branch_ok(branch_ok), .drop_sec(drop_sec),
    .drop_lost(drop_lost), .seq_q(seq_q), .br_count(br_count),
    .seq_ovf(seq_ovf), .msg_ovf(msg_ovf)
  );

  tsm_sync_ctrl ctl_u (
    .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .lp_exit(lp_exit),
    .evt_in(evt_in), .evt_allow(evt_allow), .mode_sw(mode_sw),
    .branch_ok(branch_ok), .drop_any(drop_any), .seq_ovf(seq_ovf),
    .msg_ovf(msg_ovf), .pend_q(pend_q), .make_sync(make_sync)
  );

  tsm_packer #(
    .ADDR_W(ADDR_W), .HIST_W(HIST_W), .CNT_W(CNT_W), .SRC_ID(SRC_ID),
    .MSG_W(MSG_W), .LEN_W(LEN_W)
  ) pack_u (
    .clk(clk), .rst_n(rst_n), .fire(branch_ok), .is_sync(make_sync),
    .count(br_count), .target(br_target), .hist(br_hist),
    .msg_valid(msg_valid), .msg_sync(msg_sync), .msg_data(msg_data),
    .msg_len(msg_len)
  );
endmodule

// File: rtl/tsm_checker.sv
module tsm_checker #(
  parameter int CNT_W = 8,
  parameter int MSG_W = 82,
  parameter int LEN_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trace_en,
  input logic             br_taken,
  input logic             br_secure,
  input logic             br_lost,
  input logic             msg_valid,
  input logic             msg_sync,
  input logic [MSG_W-1:0] msg_data,
  input logic [LEN_W-1:0] msg_len,
  input logic [CNT_W-1:0] seq_q,
  input logic             pend_q,
  input logic             make_sync,
  input logic             msg_ovf
);
  // R1
  code_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_data[5:0] == (msg_sync ? 6'b011101 : 6'b000100)));
  // R1
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_len >= LEN_W'(13) && msg_len <= LEN_W'(MSG_W)));
  // R1
  upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> ((msg_data >> msg_len) == '0));
  // R4
  valid_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> $past(trace_en));
  // R8
  secure_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_en && br_taken && br_secure) |=> !msg_valid);
  // R9
  lost_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trace_en && br_taken && br_lost) |=> !msg_valid);
  // R10
  seq_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_q != {CNT_W{1'b1}});
  // R12
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (make_sync && !msg_ovf) |=> !pend_q);
  // R12
  sync_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    make_sync |=> (msg_valid && msg_sync));
endmodule

bind trace_sync_msg_gen tsm_checker #(.CNT_W(CNT_W), .MSG_W(MSG_W), .LEN_W(LEN_W)) chk_u (
  .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .br_taken(br_taken),
  .br_secure(br_secure), .br_lost(br_lost), .msg_valid(msg_valid),
  .msg_sync(msg_sync), .msg_data(msg_data), .msg_len(msg_len),
  .seq_q(seq_q), .pend_q(pend_q), .make_sync(make_sync), .msg_ovf(msg_ovf)
);

// File: tb/trace_sync_msg_gen_test.sv
module trace_sync_msg_gen_test;
  localparam int P = 10;
  localparam logic [3:0] SRC = 4'hA;

  // stimulus bits {en,ins,br,sec,lost,lp,evt,evok,mode}
  localparam logic [8:0] EN = 9'h100, INS = 9'h080, BR = 9'h040, SEC = 9'h020,
    LOST = 9'h010, LPX = 9'h008, EVT = 9'h004, EVOK = 9'h002, MSW = 9'h001;

  typedef struct packed {
    logic [8:0]  st;
    logic [31:0] a;
    logic [31:0] h;
    logic        ev;
    logic        es;
    logic [7:0]  ec;
    logic [3:0]  rq;
  } vec_t;

  localparam vec_t TBL [32] = '{
    '{EN|INS,      32'h0,   32'h0,  1'b0, 1'b0, 8'd0, 4'd3},
    '{EN|INS,      32'h0,   32'h0,  1'b0, 1'b0, 8'd0, 4'd3},
    '{EN|BR,       32'h100, 32'h1,  1'b1, 1'b1, 8'd3, 4'd2},
    '{EN|INS,      32'h0,   32'h0,  1'b0, 1'b0, 8'd0, 4'd3},
    '{EN|BR,       32'h104, 32'h5,  1'b1, 1'b0, 8'd2, 4'd1},
    '{EN|BR|LPX,   32'h200, 32'h3,  1'b1, 1'b1, 8'd1, 4'd12},
    '{EN|LPX,      32'h0,   32'h0,  1'b0, 1'b0, 8'd0, 4'd5},
    '{EN|BR,       32'h210, 32'h80, 1'b1, 1'b1, 8'd1, 4'd5},
    '{EN|BR,       32'h220, 32'h0,  1'b1, 1'b0, 8'd1, 4'd1},
    '{EN|BR|SEC,   32'h8000,32'h1,  1'b0, 1'b0, 8'd0, 4'd8},
    '{EN|INS,      32'h0,   32'h0,  1'b0, 1'b0, 8'd0, 4'd8},
    '{EN|BR,       32'h230, 32'h7,  1'b1, 1'b1, 8'd2, 4'd8},
    '{EN|INS,      32'h0,   32'h0,  1'b0, 1'b0, 8'd0, 4'd9},
    '{EN|BR|LOST,  32'h240, 32'h1,  1'b0, 1'b0, 8'd0, 4'd9},
    '{EN|INS,      32'h0,   32'h0,  1'b0, 1'b0, 8'd0, 4'd9},
    '{EN|BR,       32'h250, 32'hF0, 1'b1, 1'b1, 8'd4, 4'd9},
    '{EN|EVT,      32'h0,   32'h0,  1'b0, 1'b0, 8'd0, 4'd6},
    '{EN|BR,       32'h260, 32'h2,  1'b1, 1'b0, 8'd1, 4'd6},
    '{EN|EVT|EVOK, 32'h0,   32'h0,  1'b0, 1'b0, 8'd0, 4'd6},
    '{EN|BR,       32'h270, 32'h1,  1'b1, 1'b1, 8'd1, 4'd6},
    '{EN|BR|MSW,   32'h280, 32'h9,  1'b1, 1'b1, 8'd1, 4'd7},
    '{EN|BR,       32'h290, 32'h1,  1'b1, 1'b0, 8'd1, 4'd7},
    '{BR,          32'h2a0, 32'h1,  1'b0, 1'b0, 8'd0, 4'd4},
    '{EN|INS,      32'h0,   32'h0,  1'b0, 1'b0, 8'd0, 4'd4},
    '{EN|BR,       32'h2b0, 32'h1,  1'b1, 1'b1, 8'd2, 4'd4},
    '{EN|BR|SEC|LOST, 32'h2c0, 32'h1, 1'b0, 1'b0, 8'd0, 4'd8},
    '{EN|BR,       32'h2d0, 32'h1,  1'b1, 1'b1, 8'd1, 4'd8},
    '{EN|BR|INS,   32'h2e0, 32'h3,  1'b1, 1'b0, 8'd1, 4'd3},
    '{EN|LPX,      32'h0,   32'h0,  1'b0, 1'b0, 8'd0, 4'd12},
    '{EN|MSW,      32'h0,   32'h0,  1'b0, 1'b0, 8'd0, 4'd12},
    '{EN|BR,       32'h300, 32'h1,  1'b1, 1'b1, 8'd1, 4'd12},
    '{EN|BR,       32'h310, 32'h1,  1'b1, 1'b0, 8'd1, 4'd12}
  };

  logic clk = 1'b0;
  always #(P/2) clk = ~clk;

  logic rst_n, trace_en, instr_ret, br_taken, br_secure, br_lost;
  logic lp_exit, evt_in, evt_allow, mode_sw;
  logic [31:0] br_target, br_hist;
  logic msg_valid, msg_sync;
  logic [81:0] msg_data;
  logic [6:0] msg_len;

  trace_sync_msg_gen #(.SRC_ID(SRC)) uut (
    .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .instr_ret(instr_ret),
    .br_taken(br_taken), .br_target(br_target), .br_hist(br_hist),
    .br_secure(br_secure), .br_lost(br_lost), .lp_exit(lp_exit),
    .evt_in(evt_in), .evt_allow(evt_allow), .mode_sw(mode_sw),
    .msg_valid(msg_valid), .msg_sync(msg_sync), .msg_data(msg_data),
    .msg_len(msg_len)
  );

  int total = 0;
  int bad = 0;
  logic [31:0] last_a = '0;

  function automatic string rname(input logic [3:0] n);
    case (n)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      4'd10: return "R10"; 4'd11: return "R11"; default: return "R12";
    endcase
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [81:0] act, input logic [81:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // bench-side packing: append fields bit by bit
  task automatic ref_msg(input logic s, input logic [7:0] c, input logic [31:0] a,
                         input logic [31:0] h, output logic [81:0] d, output int n);
    logic [5:0] code;
    int hi;
    d = '0; n = 0;
    code = s ? 6'b011101 : 6'b000100;
    for (int i = 0; i < 6; i++) begin d[n] = code[i]; n++; end
    for (int i = 0; i < 4; i++) begin d[n] = SRC[i]; n++; end
    hi = 1; for (int i = 0; i < 8; i++) if (c[i]) hi = i + 1;
    for (int i = 0; i < hi; i++) begin d[n] = c[i]; n++; end
    hi = 1; for (int i = 0; i < 32; i++) if (a[i]) hi = i + 1;
    for (int i = 0; i < hi; i++) begin d[n] = a[i]; n++; end
    hi = 1; for (int i = 0; i < 32; i++) if (h[i]) hi = i + 1;
    for (int i = 0; i < hi; i++) begin d[n] = h[i]; n++; end
  endtask

  task automatic drive(input logic [8:0] st, input logic [31:0] a, input logic [31:0] h);
    {trace_en, instr_ret, br_taken, br_secure, br_lost, lp_exit, evt_in, evt_allow, mode_sw} = st;
    br_target = a;
    br_hist = h;
  endtask

  task automatic step(input logic [8:0] st, input logic [31:0] a, input logic [31:0] h,
                      input logic ev, input logic es, input logic [7:0] ec, input string rq);
    logic [81:0] ed;
    logic [31:0] fa;
    int en;
    @(negedge clk);
    drive(st, a, h);
    @(posedge clk);
    #(P/4);
    chk(msg_valid == ev, rq, "valid", 82'(msg_valid), 82'(ev));
    if (ev) begin
      fa = es ? a : (a ^ last_a);
      ref_msg(es, ec, fa, h, ed, en);
      chk(msg_sync == es, rq, "sync", 82'(msg_sync), 82'(es));
      chk(msg_data == ed, rq, "data", msg_data, ed);
      chk(msg_len == 7'(en), rq, "len", 82'(msg_len), 82'(en));
      last_a = a;
    end
  endtask

  initial begin
    #(P * 150000);
    bad++;
    $display("FAIL watchdog expired before all R checks finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive('0, '0, '0);
    repeat (2) @(posedge clk);
    #(P/4);
    // R2 reset state
    chk(msg_valid == 1'b0 && msg_len == 7'd0, "R2", "reset", 82'({msg_valid, msg_len}), 82'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < 32; k++)
      step(TBL[k].st, TBL[k].a, TBL[k].h, TBL[k].ev, TBL[k].es, TBL[k].ec, rname(TBL[k].rq));

    // R11: 16 messages so far; messages 17..255 plain, 256th sync, then plain
    for (int k = 17; k <= 255; k++) step(EN|BR, 32'h310, 32'h0, 1'b1, 1'b0, 8'd1, "R11");
    step(EN|BR, 32'h320, 32'h0, 1'b1, 1'b1, 8'd1, "R11");
    step(EN|BR, 32'h320, 32'h0, 1'b1, 1'b0, 8'd1, "R11");

    // R10: 254 instructions give count 255; mode switch makes it a full-width sync
    for (int k = 0; k < 254; k++) step(EN|INS, '0, '0, 1'b0, 1'b0, 8'd0, "R10");
    step(EN|BR|MSW, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1, 8'd255, "R1");
    for (int k = 0; k < 255; k++) step(EN|INS, '0, '0, 1'b0, 1'b0, 8'd0, "R10");
    step(EN|BR, 32'h500, 32'h1, 1'b1, 1'b1, 8'd1, "R10");
    step(EN|BR, 32'h500, 32'h0, 1'b1, 1'b0, 8'd1, "R10");

    // R2: reset mid-run, then first branch is a sync
    @(negedge clk);
    rst_n = 1'b0;
    drive(EN|BR, 32'h600, 32'h1);
    @(posedge clk);
    #(P/4);
    chk(msg_valid == 1'b0, "R2", "valid in reset", 82'(msg_valid), 82'd0);
    @(negedge clk);
    rst_n = 1'b1;
    drive('0, '0, '0);
    last_a = '0;
    step(EN|INS, '0, '0, 1'b0, 1'b0, 8'd0, "R2");
    step(EN|INS, '0, '0, 1'b0, 1'b0, 8'd0, "R2");
    step(EN|BR, 32'h400, 32'h2, 1'b1, 1'b1, 8'd3, "R2");
    step(EN|BR, 32'h404, 32'h2, 1'b1, 1'b0, 8'd1, "R2");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule